// File: doc/BRIEF.md
# Three-Share Masked Serial Adder

This block adds two words modulo 2^W (W = 32 by default) while both operands stay split into three Boolean shares: the true value of an operand is the XOR of its three share words, and neither operand nor the sum is ever recombined inside the block. The result leaves as three share words whose XOR is the arithmetic sum. Only XOR, AND and registers are used, so the block can sit next to other Boolean-masked datapath logic with no arithmetic/Boolean mask conversion.

The adder is bit-serial. Operand shares sit in shift registers that drop two bits every second cycle. A shared majority function produces the carry as three shares. Each share of its output depends on only two of the three input share indices, and every output is captured in a register. Two copies of this function feed two carry registers that load on alternate cycles, so no carry value ever feeds its own logic through a combinational path. Sum bits are formed one cycle after their carries, from delayed operand bits, and are written back into the top of the operand-A shift register. When the run ends, that register holds the sum shares. The carry chain starts from a fresh random sharing of zero built from four random bits, which are sampled only when an addition is accepted.

Input side: a valid/ready transfer. `in_ready` is high only when the block is idle, and the share words and random bits are taken on the edge where `in_valid` and `in_ready` are both high. Output side: once `out_valid` rises, it stays high and the output words stay frozen until `out_ready` is seen high on an edge. No new input is accepted before that. The upstream side may hold `in_valid` high at any time. While the block is busy, the values on its inputs have no effect.

Top module: `masked_serial_adder`

## Requirements
- R1: Out of reset `in_ready` is 1 and `out_valid` is 0. `in_ready` is 1 exactly while the block is idle. An operand pair is taken on a rising edge where `in_valid` and `in_ready` are both 1, and `in_ready` is 0 on the following cycle.
- R2: `out_valid` rises on the 33rd rising edge after the accepting edge (W + 1 edges in general). It then stays at 1, with all three output share words unchanged, until an edge where `out_ready` is 1. After that edge `out_valid` is 0 and `in_ready` is 1.
- R3: While `out_valid` is 1, `s_sh0 ^ s_sh1 ^ s_sh2` equals `((a_sh0^a_sh1^a_sh2) + (b_sh0^b_sh1^b_sh2)) mod 2^W`, taking the share words present on the accepting edge.
- R4: The recombined result does not depend on how the operands are split into shares, nor on the four random bits `rnd[3:0]`. An all-zero split with `rnd = 0` gives the same sum as random splits.
- R5: The carry into bit 0 is zero: 0 + 0 gives 0 and 1 + 0 gives 1.
- R6: The carry out of the top bit is discarded: 0xFFFFFFFF + 1 gives 0.
- R7: `in_valid` and input data presented while the block is not ready have no effect on the result that is returned.
- R8: A carry that ripples through every bit position is handled: 0xFFFFFFFF + 0xFFFFFFFF gives 0xFFFFFFFE, and 0x7FFFFFFF + 1 gives 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand shares and random bits are valid |
| in_ready | output | 1 | Block is idle and will take an operand pair |
| a_sh0 | input | W | Operand A, share word 0 |
| a_sh1 | input | W | Operand A, share word 1 |
| a_sh2 | input | W | Operand A, share word 2 |
| b_sh0 | input | W | Operand B, share word 0 |
| b_sh1 | input | W | Operand B, share word 1 |
| b_sh2 | input | W | Operand B, share word 2 |
| rnd | input | 4 | Fresh random bits used to seed the two carry registers |
| out_valid | output | 1 | Sum shares are valid and held |
| out_ready | input | 1 | Consumer takes the sum shares |
| s_sh0 | output | W | Sum, share word 0 |
| s_sh1 | output | W | Sum, share word 1 |
| s_sh2 | output | W | Sum, share word 2 |

## Verification
On every cycle, the assertions check the handshake rules: busy after acceptance, output held under back-pressure, ready again after release. They also check that the two carry registers never load in the same cycle, that the seeded initial carry recombines to zero, and that the recombined output matches the arithmetic sum of the accepted operands. Only the bench scenarios show the exact latency from acceptance to `out_valid`, that results do not depend on the sharing and random bits, the wrap-around and full-chain carry cases, and that input activity during a run has no effect. The bench covers these with fixed corner operands, random operands with random sharings, noisy input during runs, and varied output stall lengths.

// File: rtl/msa_pkg.sv
package msa_pkg;
  // Masking order is fixed: a first-order sharing of a degree-two carry function needs three shares.
  localparam int SHARES = 3;

  // One bit held as three Boolean shares, index = share number.
  typedef logic [SHARES-1:0] trio_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } msa_state_t;
endpackage

// File: rtl/msa_carry_fn.sv
// Shared majority(x, y, z): output share k uses only input shares (k+1)%3 and (k+2)%3.
module msa_carry_fn
  import msa_pkg::*;
(
  input  trio_t x,
  input  trio_t y,
  input  trio_t z,
  output trio_t maj
);
  for (genvar k = 0; k < SHARES; k++) begin : g_share
    localparam int I = (k + 1) % SHARES;
    localparam int J = (k + 2) % SHARES;
    logic t_xy, t_xz, t_yz;
    assign t_xy = (x[I] & y[I]) ^ (x[I] & y[J]) ^ (x[J] & y[I]);
    assign t_xz = (x[I] & z[I]) ^ (x[I] & z[J]) ^ (x[J] & z[I]);
    assign t_yz = (y[I] & z[I]) ^ (y[I] & z[J]) ^ (y[J] & z[I]);
    assign maj[k] = t_xy ^ t_xz ^ t_yz;
  end
endmodule

// File: rtl/msa_share_sr.sv
// Three parallel shift registers, one per share, moving two bits per shift.
module msa_share_sr
  import msa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [SHARES-1:0][W-1:0]   ld_val,
  input  logic                       shift2,
  input  logic                       ins_en,
  input  trio_t                      ins_lo,
  input  trio_t                      ins_hi,
  output trio_t                      bit0,
  output trio_t                      bit1,
  output logic [SHARES-1:0][W-1:0]   word
);
  for (genvar k = 0; k < SHARES; k++) begin : g_share
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (load) begin
        r <= ld_val[k];
      end else if (shift2) begin
        r <= {2'b00, r[W-1:2]};
      end else if (ins_en) begin
        r[W-1:W-2] <= {ins_hi[k], ins_lo[k]};
      end
    end
    assign word[k] = r;
    assign bit0[k] = r[0];
    assign bit1[k] = r[1];
  end

  // A shift and an insertion never coincide (R3).
  p_no_shift_insert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift2 && ins_en));
endmodule

// File: rtl/msa_carry_pipe.sv
// Two alternating carry registers, sum delay registers and share-wise sum formation.
module msa_carry_pipe
  import msa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed,
  input  logic [3:0] rnd,
  input  logic       c0_en,
  input  logic       c1_en,
  input  trio_t      a_b0,
  input  trio_t      a_b1,
  input  trio_t      b_b0,
  input  trio_t      b_b1,
  output trio_t      sum_lo,
  output trio_t      sum_hi
);
  trio_t c0_q, c1_q;     // carry into odd bit / carry into even bit
  trio_t c0_d, c1_d;
  trio_t dly_c, dly_a0, dly_a1, dly_b0, dly_b1;

  // Even cycle: carry into bit 2k+1 from bit 2k and the carry held in c1_q.
  msa_carry_fn u_fn_even (.x(a_b0), .y(b_b0), .z(c1_q), .maj(c0_d));
  // Odd cycle: carry into bit 2k+2 from bit 2k+1 and the carry held in c0_q.
  msa_carry_fn u_fn_odd  (.x(a_b1), .y(b_b1), .z(c0_q), .maj(c1_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c0_q <= '0;
      c1_q <= '0;
    end else if (seed) begin
      c1_q <= {rnd[0] ^ rnd[1], rnd[1], rnd[0]};
      c0_q <= {rnd[2] ^ rnd[3], rnd[3], rnd[2]};
    end else begin
      if (c0_en) c0_q <= c0_d;
      if (c1_en) c1_q <= c1_d;
    end
  end

  // Delay stage, enabled with the odd-cycle carry register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_c  <= '0;
      dly_a0 <= '0;
      dly_a1 <= '0;
      dly_b0 <= '0;
      dly_b1 <= '0;
    end else if (c1_en) begin
      dly_c  <= c1_q;
      dly_a0 <= a_b0;
      dly_a1 <= a_b1;
      dly_b0 <= b_b0;
      dly_b1 <= b_b1;
    end
  end

  // Linear sum, share by share: share k mixes only share k of each term.
  assign sum_lo = dly_a0 ^ dly_b0 ^ dly_c;
  assign sum_hi = dly_a1 ^ dly_b1 ^ c0_q;

  // The seeded carry into bit 0 recombines to zero (R5).
  p_seed_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (^c1_q) == 1'b0);
  // The two carry registers load on alternate cycles (R3).
  p_even_keeps_odd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c0_en && !seed) |=> $stable(c1_q));
  p_odd_keeps_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_en && !seed) |=> $stable(c0_q));
endmodule

// File: rtl/msa_ctrl.sv
// Sequencing: idle, W+1 run cycles alternating even/odd, then hold until taken.
module msa_ctrl
  import msa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic accept,
  output logic c0_en,
  output logic c1_en,
  output logic shift2,
  output logic wr_sum
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  msa_state_t state;
  logic [CW-1:0] cyc;
  logic run, even;

  assign run       = (state == ST_RUN);
  assign even      = run && !cyc[0];
  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_HOLD);
  assign accept    = in_ready && in_valid;
  assign c0_en     = even && (cyc != LAST);
  assign c1_en     = run && cyc[0];
  assign shift2    = c1_en;
  assign wr_sum    = even && (cyc != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cyc   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          state <= ST_RUN;
          cyc   <= '0;
        end
        ST_RUN: if (cyc == LAST) begin
          state <= ST_HOLD;
          cyc   <= '0;
        end else begin
          cyc <= cyc + 1'b1;
        end
        ST_HOLD: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid));
  p_odd_alternates_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c1_en |=> !c1_en);
endmodule

// File: rtl/masked_serial_adder.sv
// Top: three-share Boolean-masked modulo-2^W serial adder. W must be even.
module masked_serial_adder
  import msa_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] a_sh0,
  input  logic [W-1:0] a_sh1,
  input  logic [W-1:0] a_sh2,
  input  logic [W-1:0] b_sh0,
  input  logic [W-1:0] b_sh1,
  input  logic [W-1:0] b_sh2,
  input  logic [3:0]   rnd,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] s_sh0,
  output logic [W-1:0] s_sh1,
  output logic [W-1:0] s_sh2
);
  logic accept, c0_en, c1_en, shift2, wr_sum;
  trio_t a_b0, a_b1, b_b0, b_b1, sum_lo, sum_hi;
  trio_t b_ins_lo, b_ins_hi;
  logic [SHARES-1:0][W-1:0] a_word, b_word;
  logic [SHARES-1:0][W-1:0] a_ld, b_ld;

  assign a_ld = {a_sh2, a_sh1, a_sh0};
  assign b_ld = {b_sh2, b_sh1, b_sh0};
  assign b_ins_lo = '0;
  assign b_ins_hi = '0;

  msa_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .accept(accept),
    .c0_en(c0_en), .c1_en(c1_en), .shift2(shift2), .wr_sum(wr_sum)
  );

  // Operand A register also collects the sum bits.
  msa_share_sr #(.W(W)) u_sr_a (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_val(a_ld), .shift2(shift2),
    .ins_en(wr_sum), .ins_lo(sum_lo), .ins_hi(sum_hi),
    .bit0(a_b0), .bit1(a_b1), .word(a_word)
  );

  msa_share_sr #(.W(W)) u_sr_b (
    .clk(clk), .rst_n(rst_n), .load(accept), .ld_val(b_ld), .shift2(shift2),
    .ins_en(1'b0), .ins_lo(b_ins_lo), .ins_hi(b_ins_hi),
    .bit0(b_b0), .bit1(b_b1), .word(b_word)
  );

  msa_carry_pipe u_carry (
    .clk(clk), .rst_n(rst_n), .seed(accept), .rnd(rnd),
    .c0_en(c0_en), .c1_en(c1_en),
    .a_b0(a_b0), .a_b1(a_b1), .b_b0(b_b0), .b_b1(b_b1),
    .sum_lo(sum_lo), .sum_hi(sum_hi)
  );

  assign s_sh0 = a_word[0];
  assign s_sh1 = a_word[1];
  assign s_sh2 = a_word[2];

  // Checking aid only: arithmetic sum of the accepted operands.
  logic [W-1:0] chk_sum;
  logic         b_unused;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_sum <= '0;
    else if (accept) chk_sum <= (a_sh0 ^ a_sh1 ^ a_sh2) + (b_sh0 ^ b_sh1 ^ b_sh2);
  end
  assign b_unused = ^b_word;

  p_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((s_sh0 ^ s_sh1 ^ s_sh2) == chk_sum));
  p_out_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(s_sh0) && $stable(s_sh1) && $stable(s_sh2)));
  p_b_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !b_unused) |-> (b_word == '0));
endmodule

// File: tb/masked_serial_adder_tb_top.sv
module masked_serial_adder_tb_top;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid;
  logic [W-1:0] a_sh0 = '0, a_sh1 = '0, a_sh2 = '0;
  logic [W-1:0] b_sh0 = '0, b_sh1 = '0, b_sh2 = '0;
  logic [3:0]   rnd = '0;
  logic [W-1:0] s_sh0, s_sh1, s_sh2;

  int n_checks = 0;
  int n_errors = 0;
  int n_cycles = 0;
  bit finished = 1'b0;
  string cur_tag = "R3";

  always #(CLK_PERIOD / 2) clk = ~clk;

  masked_serial_adder #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_sh0(a_sh0), .a_sh1(a_sh1), .a_sh2(a_sh2),
    .b_sh0(b_sh0), .b_sh1(b_sh1), .b_sh2(b_sh2),
    .rnd(rnd), .out_valid(out_valid), .out_ready(out_ready),
    .s_sh0(s_sh0), .s_sh1(s_sh1), .s_sh2(s_sh2)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  // Behavioural reference: expected handshake state and sum, compared every clock.
  typedef enum {M_IDLE, M_RUN, M_HOLD} mstate_t;
  mstate_t m_st = M_IDLE;
  int m_cnt = 0;
  logic [W-1:0] m_exp = '0;
  string m_tag = "R3";

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(in_ready == (m_st == M_IDLE), "R1", "in_ready", W'(in_ready), W'(m_st == M_IDLE));
      check(out_valid == (m_st == M_HOLD), "R2", "out_valid", W'(out_valid), W'(m_st == M_HOLD));
      if (m_st == M_HOLD)
        check((s_sh0 ^ s_sh1 ^ s_sh2) == m_exp, m_tag, "recombined sum",
              s_sh0 ^ s_sh1 ^ s_sh2, m_exp);
      case (m_st)
        M_IDLE: if (in_valid) begin
          m_exp = (a_sh0 ^ a_sh1 ^ a_sh2) + (b_sh0 ^ b_sh1 ^ b_sh2);
          m_tag = cur_tag;
          m_cnt = 0;
          m_st  = M_RUN;
        end
        M_RUN: begin
          m_cnt++;
          if (m_cnt == W + 1) m_st = M_HOLD;
        end
        M_HOLD: if (out_ready) m_st = M_IDLE;
        default: m_st = M_IDLE;
      endcase
    end
  end

  always @(posedge clk) begin
    n_cycles++;
    if (n_cycles > WATCHDOG && !finished) begin
      n_errors++;
      $display("FAIL R2 watchdog actual=%0d cycles expected=%0d", n_cycles, WATCHDOG);
      report();
    end
  end

  task automatic run_add(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] ma1, input logic [W-1:0] ma2,
                         input logic [W-1:0] mb1, input logic [W-1:0] mb2,
                         input logic [3:0] r, input int hold, input bit noisy,
                         input string tag);
    @(posedge clk); #1;
    a_sh0 = a ^ ma1 ^ ma2; a_sh1 = ma1; a_sh2 = ma2;
    b_sh0 = b ^ mb1 ^ mb2; b_sh1 = mb1; b_sh2 = mb2;
    rnd = r; cur_tag = tag; in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk); #1;
    if (noisy) begin
      a_sh0 = $urandom; b_sh1 = $urandom; rnd = 4'($urandom);
    end else begin
      in_valid = 1'b0;
    end
    while (!out_valid) begin
      @(posedge clk); #1;
      if (noisy) begin
        a_sh2 = $urandom; b_sh0 = $urandom;
      end
    end
    in_valid = 1'b0;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); #1;
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  task automatic run_rand(input logic [W-1:0] a, input logic [W-1:0] b,
                          input int hold, input bit noisy, input string tag);
    run_add(a, b, $urandom, $urandom, $urandom, $urandom, 4'($urandom), hold, noisy, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1", "in_ready in reset", W'(in_ready), W'(1));
    check(out_valid == 1'b0, "R1", "out_valid in reset", W'(out_valid), W'(0));
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", W'(in_ready), W'(1));

    // R5: zero carry into bit 0
    run_rand(32'h0, 32'h0, 0, 1'b0, "R5");
    run_rand(32'h1, 32'h0, 0, 1'b0, "R5");
    // R6: wrap-around drops the top carry
    run_rand(32'hFFFF_FFFF, 32'h1, 2, 1'b0, "R6");
    // R8: carries through every position
    run_rand(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0, "R8");
    run_rand(32'h7FFF_FFFF, 32'h1, 1, 1'b0, "R8");
    // R4: unshared operands, zero seed, versus random sharings of the same values
    run_add(32'hDEAD_BEEF, 32'h1234_5678, '0, '0, '0, '0, 4'h0, 0, 1'b0, "R4");
    run_add(32'hDEAD_BEEF, 32'h1234_5678, '0, '0, '0, '0, 4'hF, 0, 1'b0, "R4");
    run_rand(32'hDEAD_BEEF, 32'h1234_5678, 0, 1'b0, "R4");
    run_rand(32'hDEAD_BEEF, 32'h1234_5678, 0, 1'b0, "R4");
    // R7: input activity while busy is ignored
    run_rand(32'h0F0F_0F0F, 32'hF0F0_F0F1, 0, 1'b1, "R7");
    run_rand($urandom, $urandom, 3, 1'b1, "R7");
    // R2: back-pressure of varying lengths
    run_rand($urandom, $urandom, 7, 1'b0, "R2");
    // R3: random operands with random sharings
    for (int n = 0; n < 24; n++) begin
      run_rand($urandom, $urandom, n % 3, n[0], "R3");
    end

    @(negedge clk);
    check(in_ready == 1'b1, "R1", "idle at end", W'(in_ready), W'(1));
    check(out_valid == 1'b0, "R2", "no pending result at end", W'(out_valid), W'(0));
    report();
  end
endmodule